// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave that lets an external host reach three kinds of target over four wires. The first is a bank of 47 read/write configuration registers. The second is a set of 14 read-only status registers that surrounding logic supplies. The third is a group of single-byte command strobes. Every transaction opens with a header byte that holds a read flag, a burst flag and a six-bit address. While the host clocks that header in, the slave clocks out a status byte. The status byte reports the chip-ready flag, the operating-mode code and the receive-queue fill level.

The address window 0x30–0x3D has two uses. With the burst flag set, it selects a single read of one status register. With the burst flag clear, the header itself is a command strobe, and the slave emits a one-clock pulse carrying the address. Configuration writes appear on a one-clock write strobe with address and data. They are also kept in internal storage so that they can be read back.

The SPI pins are sampled by the fast system clock through two-stage synchronizers. The serial clock must therefore stay well below a quarter of the system clock rate. The bus uses SPI mode 0.

Top module: `spi_reg_slave`

## Requirements
- R1: The header byte is sent MSB first as {read, burst, addr[5:0]}. Read = 1 selects a read and read = 0 a write. Burst = 1 selects burst access, except inside the window 0x30–0x3D.
- R2: On a write, the status byte is shifted out on `so` during the header and during every data byte. A non-burst write to an address in 0x00–0x2E produces exactly one `wr_en` pulse with that address and data.
- R3: On a read, the status byte is shifted out during the header only. The addressed register's contents are shifted out during the next byte, so a configuration register returns the value last written to it.
- R4: With burst = 1 outside 0x30–0x3D, the address advances by one after each completed data byte until `csn` rises. Writes land only at addresses 0x00–0x2E, and burst reads past 0x2E return 0x00.
- R5: A header with burst = 0 and an address in 0x30–0x3D produces one single-clock `strobe_pulse` with `strobe_code` equal to the address. Any further bytes before `csn` rises produce no write and no further strobe.
- R6: A header with burst = 1 and an address in 0x30–0x3D reads status register (addr − 0x30) from `status_regs[8*i +: 8]` as a single access. A write with such a header produces no `wr_en`.
- R7: A read of 0x2F, 0x3E or 0x3F returns 0x00, and a write to any of them produces no `wr_en`.
- R8: Without burst, only the first data byte is acted on. Later bytes produce no write and read as 0x00.
- R9: If `csn` rises in the middle of a byte, the partial byte is dropped and the next transaction starts with a fresh header.
- R10: The status byte is {`rdy_n`, `mode_code[2:0]`, `fifo_level[3:0]`}, sampled when `csn` falls.
- R11: `so_oe` is 1 only while `csn` is low. After reset `so_oe`, `wr_en` and `strobe_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| csn | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for `so` |
| rdy_n | input | 1 | Chip-not-ready flag for the status byte |
| mode_code | input | 3 | Operating-mode code for the status byte |
| fifo_level | input | 4 | Receive-queue fill level for the status byte |
| status_regs | input | 112 | Fourteen read-only status registers, register i at bits 8*i+7:8*i |
| wr_en | output | 1 | One-clock configuration write pulse |
| wr_addr | output | 6 | Configuration write address |
| wr_data | output | 8 | Configuration write data |
| strobe_pulse | output | 1 | One-clock command strobe pulse |
| strobe_code | output | 6 | Address of the issued command strobe |

## Verification
The bench runs a burst write that straddles the end of the configuration bank. A design that did not bound its address counter would issue writes at 0x2F and 0x30. A design that did not advance the counter would overwrite one register again and again. It sends bytes after a command strobe and after a non-burst access. A missing ignore state would show up as extra writes, repeated strobes or stale read data. It also raises chip select in the middle of a header, where a bit counter that is not cleared would shift every later byte out of alignment. The status-window reads and writes, and the reads of holes in the map, expose any mix-up between status, strobe and configuration decoding.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int CFG_LAST   = 6'h2E,
  parameter int STAT_FIRST = 6'h30,
  parameter int STAT_LAST  = 6'h3D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        csn,
  input  logic        si,
  output logic        so,
  output logic        so_oe,
  input  logic        rdy_n,
  input  logic [2:0]  mode_code,
  input  logic [3:0]  fifo_level,
  input  logic [(STAT_LAST-STAT_FIRST+1)*8-1:0] status_regs,
  output logic        wr_en,
  output logic [5:0]  wr_addr,
  output logic [7:0]  wr_data,
  output logic        strobe_pulse,
  output logic [5:0]  strobe_code
);
  localparam int CFG_N  = CFG_LAST + 1;
  localparam int STAT_N = STAT_LAST - STAT_FIRST + 1;

  logic [1:0] sclk_q, cs_q, si_q;
  logic       sclk_d, cs_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx;
  logic [7:0] tx, nxt_q;
  logic       load_pend, hdr_done, rd, burst, stat_mode, ignore;
  logic [5:0] addr;
  logic [7:0] cfg [CFG_N];

  wire sclk_rise = sclk_q[1] & ~sclk_d;
  wire sclk_fall = ~sclk_q[1] & sclk_d;
  wire cs_fall   = ~cs_q[1] & cs_d;
  wire [7:0] rx_full  = {rx, si_q[1]};
  wire [7:0] stat_byte = {rdy_n, mode_code, fifo_level};
  wire       single   = ~burst | stat_mode;

  function automatic logic in_stat(input logic [5:0] a);
    return (int'(a) >= STAT_FIRST) && (int'(a) <= STAT_LAST);
  endfunction

  logic [5:0] sel_addr;
  logic       sel_stat;
  logic [7:0] rdata, nxt_byte;
  logic [5:0] stat_idx;

  always_comb begin
    if (hdr_done) begin
      sel_addr = (burst && !stat_mode) ? addr + 6'd1 : addr;
      sel_stat = stat_mode;
    end else begin
      sel_addr = rx_full[5:0];
      sel_stat = rx_full[6] && in_stat(rx_full[5:0]);
    end
    stat_idx = sel_addr - 6'(STAT_FIRST);
    if (sel_stat && int'(stat_idx) < STAT_N)
      rdata = status_regs[stat_idx*8 +: 8];
    else if (int'(sel_addr) <= CFG_LAST)
      rdata = cfg[sel_addr];
    else
      rdata = 8'h00;
    if (!hdr_done)
      nxt_byte = (rx_full[7] && !(!rx_full[6] && in_stat(rx_full[5:0]))) ? rdata : stat_byte;
    else if (rd)
      nxt_byte = (ignore || single) ? 8'h00 : rdata;
    else
      nxt_byte = stat_byte;
  end

  assign so    = tx[7];
  assign so_oe = ~cs_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0; sclk_d <= 1'b0;
      cs_q   <= '1; cs_d   <= 1'b1;
      si_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[0], sclk}; sclk_d <= sclk_q[1];
      cs_q   <= {cs_q[0], csn};    cs_d   <= cs_q[1];
      si_q   <= {si_q[0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; rx <= '0; tx <= '0; nxt_q <= '0;
      load_pend <= 1'b0; hdr_done <= 1'b0; rd <= 1'b0; burst <= 1'b0;
      stat_mode <= 1'b0; ignore <= 1'b0; addr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      strobe_pulse <= 1'b0; strobe_code <= '0;
      for (int i = 0; i < CFG_N; i++) cfg[i] <= '0;
    end else begin
      wr_en        <= 1'b0;
      strobe_pulse <= 1'b0;
      if (cs_q[1]) begin
        bit_cnt   <= '0;
        hdr_done  <= 1'b0;
        ignore    <= 1'b0;
        load_pend <= 1'b0;
      end else begin
        if (cs_fall) tx <= stat_byte;
        if (sclk_rise) begin
          rx      <= rx_full[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            load_pend <= 1'b1;
            nxt_q     <= nxt_byte;
            if (!hdr_done) begin
              hdr_done  <= 1'b1;
              rd        <= rx_full[7];
              burst     <= rx_full[6];
              addr      <= rx_full[5:0];
              stat_mode <= rx_full[6] && in_stat(rx_full[5:0]);
              if (!rx_full[6] && in_stat(rx_full[5:0])) begin
                strobe_pulse <= 1'b1;
                strobe_code  <= rx_full[5:0];
                ignore       <= 1'b1;
              end
            end else if (!ignore) begin
              if (!rd && !stat_mode && int'(addr) <= CFG_LAST) begin
                cfg[addr] <= rx_full;
                wr_en     <= 1'b1;
                wr_addr   <= addr;
                wr_data   <= rx_full;
              end
              addr <= sel_addr;
              if (single) ignore <= 1'b1;
            end
          end
        end
        if (sclk_fall) begin
          tx        <= load_pend ? nxt_q : {tx[6:0], 1'b0};
          load_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       so_oe,
  input logic       wr_en,
  input logic [5:0] wr_addr,
  input logic       strobe_pulse,
  input logic [5:0] strobe_code
);
  assert_strobe_one_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_pulse |=> !strobe_pulse);
  assert_strobe_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_pulse |-> (strobe_code >= 6'h30 && strobe_code <= 6'h3D));
  assert_write_in_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr <= 6'h2E);
  assert_write_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_events_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || strobe_pulse) |-> so_oe);
  assert_no_write_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && strobe_pulse));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .so_oe(so_oe), .wr_en(wr_en), .wr_addr(wr_addr),
  .strobe_pulse(strobe_pulse), .strobe_code(strobe_code)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int HALF = 6;
  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, si = 0;
  logic rdy_n = 0;
  logic [2:0] mode_code = 3'b001;
  logic [3:0] fifo_level = 4'd5;
  logic [111:0] status_regs;
  logic so, so_oe, wr_en, strobe_pulse;
  logic [5:0] wr_addr, strobe_code;
  logic [7:0] wr_data;
  int checks = 0, fails = 0, wr_cnt = 0, st_cnt = 0;
  logic [5:0] last_wa, last_sc;
  logic [7:0] last_wd;
  bit done = 0;

  always #10 clk = ~clk;

  spi_reg_slave dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .si(si), .so(so),
    .so_oe(so_oe), .rdy_n(rdy_n), .mode_code(mode_code), .fifo_level(fifo_level),
    .status_regs(status_regs), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .strobe_pulse(strobe_pulse), .strobe_code(strobe_code));

  always @(negedge clk) begin
    if (wr_en) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
    if (strobe_pulse) begin st_cnt++; last_sc = strobe_code; end
  end

  task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_begin();
    csn = 0; repeat (HALF) @(negedge clk);
  endtask
  task automatic cs_end();
    repeat (HALF) @(negedge clk); csn = 1; repeat (2*HALF) @(negedge clk);
  endtask
  task automatic xfer(input [7:0] b, output [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = so; sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic t_reset();
    chk("R11 so_oe after reset", so_oe, 0);
    chk("R11 wr_en after reset", wr_en, 0);
    chk("R11 strobe after reset", strobe_pulse, 0);
  endtask

  task automatic t_single_write();
    logic [7:0] r0, r1; int w0 = wr_cnt;
    cs_begin();
    chk("R11 so_oe while selected", so_oe, 1);
    xfer(8'h05, r0); xfer(8'hA5, r1); cs_end();
    chk("R10 status during header", r0, 8'h15);
    chk("R2 status during write data", r1, 8'h15);
    chk("R2 write count", wr_cnt - w0, 1);
    chk("R2 write addr", last_wa, 6'h05);
    chk("R2 write data", last_wd, 8'hA5);
  endtask

  task automatic t_single_read();
    logic [7:0] r0, r1, r2; int w0 = wr_cnt;
    cs_begin(); xfer(8'h85, r0); xfer(8'h00, r1); xfer(8'h00, r2); cs_end();
    chk("R3 status during read header", r0, 8'h15);
    chk("R3 read data", r1, 8'hA5);
    chk("R8 extra read byte is zero", r2, 8'h00);
    chk("R1 read makes no write", wr_cnt - w0, 0);
  endtask

  task automatic t_burst();
    logic [7:0] r; logic [7:0] rd [4]; int w0 = wr_cnt;
    cs_begin(); xfer(8'h6D, r);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); xfer(8'h44, r); cs_end();
    chk("R4 burst writes stop at bank end", wr_cnt - w0, 2);
    chk("R4 last burst write addr", last_wa, 6'h2E);
    cs_begin(); xfer(8'hEC, r);
    for (int i = 0; i < 4; i++) xfer(8'h00, rd[i]);
    cs_end();
    chk("R4 burst read 0x2C", rd[0], 8'h00);
    chk("R4 burst read 0x2D", rd[1], 8'h11);
    chk("R4 burst read 0x2E", rd[2], 8'h22);
    chk("R7 burst read 0x2F", rd[3], 8'h00);
  endtask

  task automatic t_strobe();
    logic [7:0] r; int w0 = wr_cnt, s0 = st_cnt;
    cs_begin(); xfer(8'h34, r); xfer(8'h55, r); xfer(8'h3A, r); cs_end();
    chk("R5 one strobe", st_cnt - s0, 1);
    chk("R5 strobe code", last_sc, 6'h34);
    chk("R5 bytes after strobe ignored", wr_cnt - w0, 0);
  endtask

  task automatic t_status_regs();
    logic [7:0] r0, r1, r2; int w0 = wr_cnt, s0 = st_cnt;
    cs_begin(); xfer(8'hF2, r0); xfer(8'h00, r1); xfer(8'h00, r2); cs_end();
    chk("R6 status header byte", r0, 8'h15);
    chk("R6 status reg 0x32", r1, 8'hA2);
    chk("R6 status read is single", r2, 8'h00);
    cs_begin(); xfer(8'h71, r0); xfer(8'hFF, r0); xfer(8'hFF, r0); cs_end();
    chk("R6 write to status ignored", wr_cnt - w0, 0);
    chk("R6 no strobe from status access", st_cnt - s0, 0);
    cs_begin(); xfer(8'hF1, r0); xfer(8'h00, r1); cs_end();
    chk("R6 status reg 0x31 read", r1, 8'hA1);
  endtask

  task automatic t_holes();
    logic [7:0] r; int w0 = wr_cnt;
    cs_begin(); xfer(8'hBF, r); xfer(8'h00, r); cs_end();
    chk("R7 read 0x3F", r, 8'h00);
    cs_begin(); xfer(8'hFE, r); xfer(8'h00, r); cs_end();
    chk("R7 burst read 0x3E", r, 8'h00);
    cs_begin(); xfer(8'h2F, r); xfer(8'h77, r); cs_end();
    chk("R7 write 0x2F discarded", wr_cnt - w0, 0);
  endtask

  task automatic t_nonburst_extra();
    logic [7:0] r; int w0 = wr_cnt;
    cs_begin(); xfer(8'h07, r); xfer(8'h12, r); xfer(8'h34, r);
    chk("R2 status on later write byte", r, 8'h15);
    cs_end();
    chk("R8 only first byte written", wr_cnt - w0, 1);
    cs_begin(); xfer(8'h87, r); xfer(8'h00, r); cs_end();
    chk("R8 register holds first byte", r, 8'h12);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    cs_begin();
    for (int i = 7; i >= 4; i--) begin
      si = i[0]; repeat (HALF) @(negedge clk); sclk = 1; repeat (HALF) @(negedge clk); sclk = 0;
    end
    cs_end();
    chk("R11 so_oe released", so_oe, 0);
    cs_begin(); xfer(8'h06, r); xfer(8'h3C, r); cs_end();
    chk("R9 addr after abort", last_wa, 6'h06);
    chk("R9 data after abort", last_wd, 8'h3C);
  endtask

  task automatic t_status_fields();
    logic [7:0] r;
    rdy_n = 1; mode_code = 3'b110; fifo_level = 4'hF;
    cs_begin(); xfer(8'h86, r); cs_end();
    chk("R10 status byte fields", r, 8'hEF);
    rdy_n = 0; mode_code = 3'b100; fifo_level = 4'h2;
    cs_begin(); xfer(8'h86, r); cs_end();
    chk("R10 status byte calibrate", r, 8'h42);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 14; i++) status_regs[i*8 +: 8] = 8'hA0 + 8'(i);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1; repeat (4) @(negedge clk);
    t_single_write();
    t_single_read();
    t_burst();
    t_strobe();
    t_status_regs();
    t_holes();
    t_nonburst_extra();
    t_abort();
    t_status_fields();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule